// File: doc/BRIEF.md
# Real-time clock with alarm and sampling interrupts

This block keeps wall-clock time for a system that counts whole days rather than calendar dates. A single-cycle register port sets and reads the time, an alarm, a prescaler reload and the interrupt controls. An external oscillator arrives as a one-cycle clock-enable pulse (`osc_pulse`) in the system clock domain. A prescaler counts those pulses. When the count reaches the programmed reload it produces a one-second tick. Binary sub-divisions of the same count give periodic sampling events from 2 Hz up to 512 Hz.

Time is held as a 16-bit free-running day number, a packed hour/minute register and a seconds register. The alarm registers use the same layout. Every event sets a sticky flag in a status register, and software clears a flag by writing one to it. The interrupt line is high while any flag is set whose enable bit is also set.

Register addresses on `bus_addr`: 0 control (bit 0 = run), 1 day, 2 hour/minute, 3 seconds, 4 alarm day, 5 alarm hour/minute, 6 alarm seconds, 7 status, 8 interrupt enable, 9 reload upper half, 10 reload lower half. Any other address reads as 0.

Top module: `rtc_alarm_core`

## Requirements
- R1: After a synchronous reset, the following all read 0: the run bit, the time registers, the alarm registers, the status and the enables, and `irq` is low. The reload reads upper 0x0000 and lower 0x8000, which is 32768 pulses per second.
- R2: The run bit reads back as written. While it is clear, oscillator pulses are ignored: no time field changes and no flag is set.
- R3: With run set, each second lasts R oscillator pulses, where R = upper*65536 + lower. A reload of 0 or 1 gives one second per pulse.
- R4: Seconds and minutes count 0..59 and hours count 0..23. Each field carries into the next field when it wraps. A wrap of the hours increments the day. A field that was written with a value above its limit wraps to 0 at its next increment.
- R5: The day count is 16 bits wide and wraps from 0xFFFF to 0 without any other effect.
- R6: Field layout: day in bits 15:0, hours in bits 12:8 and minutes in bits 5:0 of the hour/minute word, seconds in bits 5:0. Other written bits are dropped. Read data appears on `bus_rdata` one clock after the address is presented.
- R7: A write to any time register takes effect at that clock edge. It restarts the prescaler, so the next second ends R pulses later. A pulse in the same cycle as such a write is discarded.
- R8: Status bit 0 (alarm) is set at the edge where the time advances to a value equal to all three alarm fields.
- R9: Status bit 1 is set on every second. For k = 1..9, status bit k+1 (rate 2^k Hz) is set on the pulse that brings the count within the second to a multiple of R >> k. R is assumed to be a power of two.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clear keeps the bit set.
- R11: `irq` is registered and equals the OR of (status AND enable) after each edge, including the edge that changes either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_pulse | input | 1 | One-cycle oscillator clock-enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a write that lands in the same cycle as an event. This covers a time write on the pulse that would close a second, and a status clear on the pulse that sets the bit being cleared. With the default reload such cycles are 32768 pulses apart. The bench first programs reloads of 1, 4 and 16 pulses, counts pulses exactly, and places the write on the closing pulse. A random phase then runs with an 8-pulse second and a cycle-accurate model to cover the remaining overlaps. The rollover from day 0xFFFF at 23:59:59 is preloaded through the time registers rather than waited for.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam int HR_W    = 5;
  localparam int MN_W    = 6;
  localparam int SC_W    = 6;
  localparam int HR_LSB  = 8;
  localparam int ST_ALARM = 0;
  localparam int ST_SEC   = 1;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_DAY  = 4'd1;
  localparam logic [ADDR_W-1:0] A_HM   = 4'd2;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'd3;
  localparam logic [ADDR_W-1:0] A_ADAY = 4'd4;
  localparam logic [ADDR_W-1:0] A_AHM  = 4'd5;
  localparam logic [ADDR_W-1:0] A_ASEC = 4'd6;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd8;
  localparam logic [ADDR_W-1:0] A_RLHI = 4'd9;
  localparam logic [ADDR_W-1:0] A_RLLO = 4'd10;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_W  = 32,
  parameter int N_SAMPLE = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                count_en,
  input  logic                restart,
  input  logic [PRESC_W-1:0]  reload,
  output logic                sec_tick,
  output logic [N_SAMPLE-1:0] sample_hit
);
  logic [PRESC_W-1:0] elapsed;
  logic [PRESC_W:0]   next_cnt;
  logic               advance;

  assign advance  = count_en && !restart;
  assign next_cnt = {1'b0, elapsed} + 1'b1;
  assign sec_tick = advance && (next_cnt >= {1'b0, reload});

  for (genvar k = 0; k < N_SAMPLE; k++) begin : g_tap
    logic [PRESC_W-1:0] div_k;
    assign div_k = reload >> (k + 1);
    assign sample_hit[k] = advance && (div_k != '0) &&
                           ((next_cnt[PRESC_W-1:0] & (div_k - 1'b1)) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      elapsed <= '0;
    end else if (count_en) begin
      elapsed <= sec_tick ? '0 : next_cnt[PRESC_W-1:0];
    end
  end

  assert_tick_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> (elapsed == '0));
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !restart) |=> $stable(elapsed));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              wr_day,
  input  logic              wr_hm,
  input  logic              wr_sec,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DAY_W-1:0]  al_day,
  input  logic [HR_W-1:0]   al_hr,
  input  logic [MN_W-1:0]   al_mn,
  input  logic [SC_W-1:0]   al_sc,
  output logic [DAY_W-1:0]  day,
  output logic [HR_W-1:0]   hr,
  output logic [MN_W-1:0]   mn,
  output logic [SC_W-1:0]   sc,
  output logic              alarm_hit
);
  logic [DAY_W-1:0] day_n;
  logic [HR_W-1:0]  hr_n;
  logic [MN_W-1:0]  mn_n;
  logic [SC_W-1:0]  sc_n;

  always_comb begin
    day_n = day;
    hr_n  = hr;
    mn_n  = mn;
    sc_n  = sc;
    if (sc >= SC_W'(59)) begin
      sc_n = '0;
      if (mn >= MN_W'(59)) begin
        mn_n = '0;
        if (hr >= HR_W'(23)) begin
          hr_n  = '0;
          day_n = day + 1'b1;
        end else begin
          hr_n = hr + 1'b1;
        end
      end else begin
        mn_n = mn + 1'b1;
      end
    end else begin
      sc_n = sc + 1'b1;
    end
  end

  assign alarm_hit = sec_tick && (day_n == al_day) && (hr_n == al_hr) &&
                     (mn_n == al_mn) && (sc_n == al_sc);

  always_ff @(posedge clk) begin
    if (rst) begin
      day <= '0;
      hr  <= '0;
      mn  <= '0;
      sc  <= '0;
    end else if (wr_day || wr_hm || wr_sec) begin
      if (wr_day) day <= wdata[DAY_W-1:0];
      if (wr_hm) begin
        hr <= wdata[HR_LSB +: HR_W];
        mn <= wdata[MN_W-1:0];
      end
      if (wr_sec) sc <= wdata[SC_W-1:0];
    end else if (sec_tick) begin
      day <= day_n;
      hr  <= hr_n;
      mn  <= mn_n;
      sc  <= sc_n;
    end
  end

  assert_sec_range_R4: assert property (@(posedge clk) disable iff (rst)
    (sc < SC_W'(60) && !wr_sec) |=> (sc < SC_W'(60)));
  assert_day_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_day && !wr_hm && !wr_sec && sc == SC_W'(59) &&
     mn == MN_W'(59) && hr == HR_W'(23)) |=> (day == DAY_W'($past(day) + 1'b1)));
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
  import rtc_pkg::*;
#(
  parameter int          DAY_W     = 16,
  parameter int          N_SAMPLE  = 9,
  parameter logic [15:0] RESET_HI  = 16'h0000,
  parameter logic [15:0] RESET_LO  = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_pulse,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int N_STAT  = N_SAMPLE + 2;
  localparam int PRESC_W = 2 * DATA_W;

  logic              run;
  logic [DAY_W-1:0]  al_day;
  logic [HR_W-1:0]   al_hr;
  logic [MN_W-1:0]   al_mn;
  logic [SC_W-1:0]   al_sc;
  logic [N_STAT-1:0] status, status_n, ien, ien_n, set_vec;
  logic [DATA_W-1:0] rl_hi, rl_lo, rd_mux;
  logic [DAY_W-1:0]  day;
  logic [HR_W-1:0]   hr;
  logic [MN_W-1:0]   mn;
  logic [SC_W-1:0]   sc;
  logic              sec_tick, alarm_hit;
  logic [N_SAMPLE-1:0] sample_hit;

  logic wr_day, wr_hm, wr_sec, wr_stat, wr_ien, time_wr;
  assign wr_day  = bus_wr && bus_addr == A_DAY;
  assign wr_hm   = bus_wr && bus_addr == A_HM;
  assign wr_sec  = bus_wr && bus_addr == A_SEC;
  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_ien  = bus_wr && bus_addr == A_IEN;
  assign time_wr = wr_day || wr_hm || wr_sec;

  rtc_prescaler #(.PRESC_W(PRESC_W), .N_SAMPLE(N_SAMPLE)) u_presc (
    .clk(clk), .rst(rst), .count_en(run && osc_pulse), .restart(time_wr),
    .reload({rl_hi, rl_lo}), .sec_tick(sec_tick), .sample_hit(sample_hit));

  rtc_timekeeper #(.DAY_W(DAY_W)) u_time (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_day(wr_day),
    .wr_hm(wr_hm), .wr_sec(wr_sec), .wdata(bus_wdata), .al_day(al_day),
    .al_hr(al_hr), .al_mn(al_mn), .al_sc(al_sc), .day(day), .hr(hr),
    .mn(mn), .sc(sc), .alarm_hit(alarm_hit));

  assign set_vec  = {sample_hit, sec_tick, alarm_hit};
  assign status_n = (wr_stat ? (status & ~bus_wdata[N_STAT-1:0]) : status) | set_vec;
  assign ien_n    = wr_ien ? bus_wdata[N_STAT-1:0] : ien;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: rd_mux = DATA_W'(run);
      A_DAY:  rd_mux = DATA_W'(day);
      A_HM:   rd_mux = DATA_W'({hr, 2'b00, mn});
      A_SEC:  rd_mux = DATA_W'(sc);
      A_ADAY: rd_mux = DATA_W'(al_day);
      A_AHM:  rd_mux = DATA_W'({al_hr, 2'b00, al_mn});
      A_ASEC: rd_mux = DATA_W'(al_sc);
      A_STAT: rd_mux = DATA_W'(status);
      A_IEN:  rd_mux = DATA_W'(ien);
      A_RLHI: rd_mux = rl_hi;
      A_RLLO: rd_mux = rl_lo;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      al_day    <= '0;
      al_hr     <= '0;
      al_mn     <= '0;
      al_sc     <= '0;
      status    <= '0;
      ien       <= '0;
      rl_hi     <= RESET_HI;
      rl_lo     <= RESET_LO;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: run    <= bus_wdata[0];
          A_ADAY: al_day <= bus_wdata[DAY_W-1:0];
          A_AHM: begin
            al_hr <= bus_wdata[HR_LSB +: HR_W];
            al_mn <= bus_wdata[MN_W-1:0];
          end
          A_ASEC: al_sc <= bus_wdata[SC_W-1:0];
          A_RLHI: rl_hi <= bus_wdata;
          A_RLLO: rl_lo <= bus_wdata;
          default: ;
        endcase
      end
      status    <= status_n;
      ien       <= ien_n;
      bus_rdata <= rd_mux;
      irq       <= |(status_n & ien_n);
    end
  end

  assert_irq_matches_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq == |(status & ien)));
  assert_alarm_sets_R8: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |=> status[ST_ALARM]);
  assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && bus_wdata[ST_SEC] && !sec_tick) |=> !status[ST_SEC]);
  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !time_wr) |=> ($stable(sc) && $stable(day)));
endmodule

// File: tb/rtc_alarm_core_test.sv
module rtc_alarm_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_alarm_core uut (.clk(clk), .rst(rst), .osc_pulse(osc), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  int m_en, m_day, m_hr, m_mn, m_sc, a_day, a_hr, a_mn, a_sc;
  int m_stat, m_ien, m_phi, m_plo, m_irq;
  longint m_el;
  logic [15:0] exp_rd;

  function automatic logic [15:0] mread(int a);
    case (a)
      0: return 16'(m_en);   1: return 16'(m_day);
      2: return 16'((m_hr << 8) | m_mn);  3: return 16'(m_sc);
      4: return 16'(a_day);  5: return 16'((a_hr << 8) | a_mn);
      6: return 16'(a_sc);   7: return 16'(m_stat);
      8: return 16'(m_ien);  9: return 16'(m_phi);
      10: return 16'(m_plo);
      default: return 16'h0;
    endcase
  endfunction

  function automatic string req_of(int a);
    if (a == 0) return "R2";
    if (a >= 1 && a <= 3) return "R4";
    if (a >= 4 && a <= 6) return "R8";
    if (a == 7) return "R9";
    if (a == 8) return "R11";
    return "R3";
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // cycle-accurate behavioural reference, evaluated on every rising edge
  always @(posedge clk) begin
    int setv;
    longint rl, n, dv;
    bit tw;
    exp_rd = rst ? 16'h0 : mread(int'(addr));
    if (rst) begin
      m_en = 0; m_day = 0; m_hr = 0; m_mn = 0; m_sc = 0;
      a_day = 0; a_hr = 0; a_mn = 0; a_sc = 0;
      m_stat = 0; m_ien = 0; m_phi = 0; m_plo = 32768; m_irq = 0; m_el = 0;
    end else begin
      setv = 0;
      rl = longint'(m_phi) * 65536 + m_plo;
      tw = wr && (addr == 1 || addr == 2 || addr == 3);
      if (tw) begin
        m_el = 0;
        if (addr == 1) m_day = int'(wdata);
        if (addr == 2) begin m_hr = (wdata >> 8) & 31; m_mn = wdata & 63; end
        if (addr == 3) m_sc = wdata & 63;
      end else if (m_en != 0 && osc) begin
        n = m_el + 1;
        for (int k = 1; k <= 9; k++) begin
          dv = rl >> k;
          if (dv != 0 && (n % dv) == 0) setv |= (1 << (k + 1));
        end
        if (n >= rl) begin
          m_el = 0;
          setv |= 2;
          if (m_sc >= 59) begin
            m_sc = 0;
            if (m_mn >= 59) begin
              m_mn = 0;
              if (m_hr >= 23) begin m_hr = 0; m_day = (m_day + 1) % 65536; end
              else m_hr++;
            end else m_mn++;
          end else m_sc++;
          if (m_day == a_day && m_hr == a_hr && m_mn == a_mn && m_sc == a_sc)
            setv |= 1;
        end else m_el = n;
      end
      if (wr) begin
        case (addr)
          0: m_en = wdata & 1;
          4: a_day = int'(wdata);
          5: begin a_hr = (wdata >> 8) & 31; a_mn = wdata & 63; end
          6: a_sc = wdata & 63;
          7: m_stat &= ~(int'(wdata) & 'h7FF);
          8: m_ien = wdata & 'h7FF;
          9: m_phi = int'(wdata);
          10: m_plo = int'(wdata);
          default: ;
        endcase
      end
      m_stat |= setv;
      m_irq = ((m_stat & m_ien) != 0) ? 1 : 0;
    end
    #2;
    checks += 2;
    if (rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s rdata addr %0d got %h expected %h", req_of(int'(addr)), addr, rdata, exp_rd);
    end
    if (int'(irq) != m_irq || $isunknown(irq)) begin
      errors++;
      $display("FAIL R11 irq got %b expected %0d", irq, m_irq);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wreg(int a, int d);
    @(negedge clk); wr = 1; osc = 0; addr = 4'(a); wdata = 16'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); wr = 0; osc = 1; end
    @(negedge clk); osc = 0;
  endtask

  task automatic rreg(int a, output int v);
    @(negedge clk); wr = 0; osc = 0; addr = 4'(a);
    @(posedge clk); #2 v = int'(rdata);
  endtask

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset values of every register
    for (int a = 0; a <= 10; a++) begin
      rreg(a, v);
      check("R1", v, (a == 10) ? 'h8000 : 0);
    end
    check("R1", int'(irq), 0);
    // R6: field positions, unused bits dropped
    wreg(2, 'hEAEB); rreg(2, v); check("R6", v, 'h0A2B);
    wreg(3, 'hFFFB); rreg(3, v); check("R6", v, 'h3B);
    wreg(3, 0);
    // R2: pulses ignored while stopped
    wreg(9, 0); wreg(10, 4);
    pulse(20); rreg(3, v); check("R2", v, 0);
    rreg(0, v); check("R2", v, 0);
    wreg(0, 1); rreg(0, v); check("R2", v, 1);
    // R5 / R4: full rollover of every field
    wreg(1, 'hFFFF); wreg(2, 'h173B); wreg(3, 59);
    pulse(3); rreg(3, v); check("R3", v, 59);
    pulse(1);
    rreg(1, v); check("R5", v, 0);
    rreg(2, v); check("R4", v, 0);
    rreg(3, v); check("R4", v, 0);
    // R7: time write restarts the prescaler
    wreg(3, 10); pulse(3); wreg(3, 20); pulse(3);
    rreg(3, v); check("R7", v, 20);
    pulse(1); rreg(3, v); check("R7", v, 21);
    // R3: reload of 1 gives one second per pulse
    wreg(10, 1); pulse(3); rreg(3, v); check("R3", v, 24);
    wreg(10, 4);
    // R8: alarm at 0d 00:00:26
    wreg(7, 'h7FF); wreg(6, 26);
    pulse(4); rreg(7, v); check("R8", v & 1, 0);
    pulse(4); rreg(7, v); check("R8", v & 1, 1);
    // R10: write-one-to-clear, write zero keeps, event wins over clear
    wreg(7, 1); rreg(7, v); check("R10", v & 3, 2);
    wreg(7, 0); rreg(7, v); check("R10", v & 3, 2);
    wreg(7, 'h7FF);
    pulse(3);
    @(negedge clk); wr = 1; osc = 1; addr = 7; wdata = 16'h7FF;
    @(negedge clk); wr = 0; osc = 0;
    rreg(7, v); check("R10", v & 2, 2);
    // R11: interrupt follows status AND enable
    wreg(8, 2); rreg(8, v); check("R11", int'(irq), 1);
    wreg(8, 0); rreg(8, v); check("R11", int'(irq), 0);
    wreg(8, 2); wreg(7, 2); rreg(7, v); check("R11", int'(irq), 0);
    // R9: sampling flags
    wreg(10, 16); wreg(3, 0); wreg(7, 'h7FF);
    pulse(2); rreg(7, v); check("R9", v, 'h30);
    wreg(10, 1024); wreg(3, 0); wreg(7, 'h7FF);
    pulse(2); rreg(7, v); check("R9", v, 'h400);
    // random phase against the model
    wreg(10, 8); wreg(8, 'h7FF);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      osc = ($urandom % 3) != 0;
      wr = ($urandom % 29) == 0;
      addr = 4'(($urandom % 8) + 1);
      wdata = 16'($urandom);
      if (!wr) addr = 4'(i % 11);
    end
    @(negedge clk); wr = 0; osc = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule